// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Queue and Clear-to-Send Gating

This block is the transmit half of an asynchronous serial port. Bytes written into a sixteen-entry queue are sent one after another on a single output line. Each character is framed by a low start bit and one or two high stop bits. An optional parity bit is inserted after the data. The bit rate is set by an external enable pulse that fires sixteen times per bit period.

The format of each character is chosen at run time: seven or eight data bits, parity off, even or odd, and one or two stop bits. The block captures the format at the moment a character is taken from the queue. An active-low clear-to-send input holds back new characters. A character already on the line is always finished.

The block reports how many entries the queue holds. It raises an empty request while the queue has drained. It keeps a sticky flag when a write was lost because the queue was full.

Top module: `async_tx_channel`

## Requirements
- R1: After reset the line is high, the fill count is 0, the empty request is 1 and the overflow flag is 0.
- R2: A character is a low start bit followed by the data bits, least significant first. With the seven-bit select high only bits 6..0 of the written byte are sent and bit 7 is dropped.
- R3: With parity enabled, one parity bit follows the last data bit. Parity-odd low makes the count of ones over data plus parity even, and parity-odd high makes it odd.
- R4: One high stop bit ends each character, or two when the two-stop select is high.
- R5: Every start, data, parity and stop bit lasts exactly 16 pulses of the sample enable, so a bit lasts 16 times the enable period.
- R6: The queue holds up to 16 bytes and sends them in write order. The fill count gives the number of stored bytes, and a byte leaves the queue when its start bit begins.
- R7: A new character starts only while clear-to-send is low. Raising it during a character lets that character finish, and no further character starts.
- R8: The empty request goes high the cycle after the fill count reaches 0 and drops the cycle after any write.
- R9: A write while the fill count is 16 is discarded and sets the overflow flag, which stays set until reset.
- R10: Format inputs that change while a character is being sent do not affect that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Enable pulse at 16 times the bit rate |
| wrEn | input | 1 | Write strobe for the queue |
| wrData | input | 8 | Byte to enqueue |
| cfgSevenBit | input | 1 | 1 selects seven data bits, 0 selects eight |
| cfgParityOn | input | 1 | 1 inserts a parity bit |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| ctsN | input | 1 | Clear-to-send, active low |
| txLine | output | 1 | Serial output, idles high |
| fillCount | output | 5 | Number of bytes held in the queue |
| emptyIrq | output | 1 | Queue-empty request |
| overflowFlag | output | 1 | Sticky lost-write flag |

## Verification
The assertions assume that every input changes only between clock edges and that reset is held at time zero. They also assume that the sample enable is a plain level, so a character may start on any cycle in which the enable is high. The bench drives all inputs on the falling edge and builds the enable from a divider that it changes only while the line is idle. It changes the format inputs only with the queue empty and idle, except in one case that deliberately changes the format in the middle of a character.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [1:0] {
    LINE_MARK   = 2'd0,
    LINE_SPACE  = 2'd1,
    LINE_DATA   = 2'd2,
    LINE_PARITY = 2'd3
  } lineSel_e;

  typedef struct packed {
    logic     pop;
    logic     shift;
    lineSel_e lineSel;
  } txStrobes_t;

endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [W-1:0]  wrData,
  input  logic          pop,
  output logic [W-1:0]  headData,
  output logic [CW-1:0] count,
  output logic          emptyIrq,
  output logic          overflowFlag
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          push, doPop, isFull;

  assign isFull   = (count == FULL_CNT);
  assign push     = wrEn && !isFull;
  assign doPop    = pop && (count != '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      count        <= '0;
      emptyIrq     <= 1'b1;
      overflowFlag <= 1'b0;
    end else begin
      if (push)  wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wrEn)             emptyIrq <= 1'b0;
      else if (count == '0) emptyIrq <= 1'b1;
      if (wrEn && isFull) overflowFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/tx_datapath.sv
module tx_datapath
  import async_tx_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [W-1:0]  wrData,
  input  logic          cfgSevenBit,
  input  logic          cfgParityOdd,
  input  txStrobes_t    strobes,
  output logic          fifoEmpty,
  output logic          txLine,
  output logic [CW-1:0] fillCount,
  output logic          emptyIrq,
  output logic          overflowFlag
);

  logic [W-1:0] headData, maskedHead, shiftReg;
  logic         parBit, lineNext;

  tx_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .pop          (strobes.pop),
    .headData     (headData),
    .count        (fillCount),
    .emptyIrq     (emptyIrq),
    .overflowFlag (overflowFlag)
  );

  assign fifoEmpty = (fillCount == '0);

  always_comb begin
    maskedHead = headData;
    if (cfgSevenBit) maskedHead[W-1] = 1'b0;
  end

  always_comb begin
    unique case (strobes.lineSel)
      LINE_SPACE:  lineNext = 1'b0;
      LINE_DATA:   lineNext = shiftReg[0];
      LINE_PARITY: lineNext = parBit;
      default:     lineNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      txLine   <= 1'b1;
    end else begin
      if (strobes.pop) begin
        shiftReg <= maskedHead;
        parBit   <= (^maskedHead) ^ cfgParityOdd;
      end else if (strobes.shift) begin
        shiftReg <= shiftReg >> 1;
      end
      txLine <= lineNext;
    end
  end

endmodule

// File: rtl/tx_control.sv
module tx_control
  import async_tx_pkg::*;
#(
  parameter int W   = 8,
  parameter int OVS = 16,
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleTick,
  input  logic       ctsN,
  input  logic       fifoEmpty,
  input  logic       cfgSevenBit,
  input  logic       cfgParityOn,
  input  logic       cfgTwoStop,
  output txStrobes_t strobes
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} txState_e;

  localparam logic [TW-1:0] TICK_LAST = TW'(OVS - 1);
  localparam logic [BW-1:0] IDX_FULL  = BW'(W - 1);
  localparam logic [BW-1:0] IDX_SHORT = BW'(W - 2);

  txState_e      state;
  logic [TW-1:0] tickCnt;
  logic [BW-1:0] bitIdx, lastIdx;
  logic          stopIdx, sevenQ, parityQ, twoStopQ, bitEnd;

  assign lastIdx = sevenQ ? IDX_SHORT : IDX_FULL;
  assign bitEnd  = sampleTick && (state != S_IDLE) && (tickCnt == TICK_LAST);

  always_comb begin
    strobes.pop   = (state == S_IDLE) && sampleTick && !fifoEmpty && !ctsN;
    strobes.shift = (state == S_DATA) && bitEnd;
    unique case (state)
      S_START: strobes.lineSel = LINE_SPACE;
      S_DATA:  strobes.lineSel = LINE_DATA;
      S_PAR:   strobes.lineSel = LINE_PARITY;
      default: strobes.lineSel = LINE_MARK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      stopIdx  <= 1'b0;
      sevenQ   <= 1'b0;
      parityQ  <= 1'b0;
      twoStopQ <= 1'b0;
    end else if (strobes.pop) begin
      state    <= S_START;
      tickCnt  <= '0;
      bitIdx   <= '0;
      stopIdx  <= 1'b0;
      sevenQ   <= cfgSevenBit;
      parityQ  <= cfgParityOn;
      twoStopQ <= cfgTwoStop;
    end else if (state != S_IDLE && sampleTick) begin
      tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
      if (bitEnd) begin
        unique case (state)
          S_START: state <= S_DATA;
          S_DATA: begin
            if (bitIdx == lastIdx) begin
              bitIdx  <= '0;
              stopIdx <= 1'b0;
              state   <= parityQ ? S_PAR : S_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
          S_PAR: begin
            stopIdx <= 1'b0;
            state   <= S_STOP;
          end
          S_STOP: begin
            if (twoStopQ && !stopIdx) stopIdx <= 1'b1;
            else                      state   <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/async_tx_channel.sv
module async_tx_channel
  import async_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgSevenBit,
  input  logic              cfgParityOn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              ctsN,
  output logic              txLine,
  output logic [CNT_W-1:0]  fillCount,
  output logic              emptyIrq,
  output logic              overflowFlag
);

  txStrobes_t strobes;
  logic       fifoEmpty;

  tx_control #(.W(DATA_W), .OVS(OVS)) ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sampleTick  (sampleTick),
    .ctsN        (ctsN),
    .fifoEmpty   (fifoEmpty),
    .cfgSevenBit (cfgSevenBit),
    .cfgParityOn (cfgParityOn),
    .cfgTwoStop  (cfgTwoStop),
    .strobes     (strobes)
  );

  tx_datapath #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .cfgSevenBit  (cfgSevenBit),
    .cfgParityOdd (cfgParityOdd),
    .strobes      (strobes),
    .fifoEmpty    (fifoEmpty),
    .txLine       (txLine),
    .fillCount    (fillCount),
    .emptyIrq     (emptyIrq),
    .overflowFlag (overflowFlag)
  );

endmodule

// File: rtl/async_tx_channel_chk.sv
module async_tx_channel_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sampleTick,
  input logic          wrEn,
  input logic          ctsN,
  input logic [CW-1:0] fillCount,
  input logic          emptyIrq,
  input logic          overflowFlag,
  input logic          popStrb
);

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fillCount) <= DEPTH); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fillCount) <= int'($past(fillCount)) + 1) &&
    (int'($past(fillCount)) <= int'(fillCount) + 1)); // R6

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    popStrb |-> (fillCount != '0)); // R6

  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    popStrb |-> !ctsN); // R7

  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    popStrb |-> sampleTick); // R5

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> !emptyIrq); // R8

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fillCount == '0 && !wrEn) |=> emptyIrq); // R8

  AST_FULL_WRITE_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && int'(fillCount) == DEPTH) |=> overflowFlag); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflowFlag |=> overflowFlag); // R9

endmodule

bind async_tx_channel async_tx_channel_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sampleTick   (sampleTick),
  .wrEn         (wrEn),
  .ctsN         (ctsN),
  .fillCount    (fillCount),
  .emptyIrq     (emptyIrq),
  .overflowFlag (overflowFlag),
  .popStrb      (strobes.pop)
);

// File: tb/async_tx_channel_tb_top.sv
module async_tx_channel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sampleTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       cfgSevenBit = 1'b0, cfgParityOn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic       ctsN = 1'b0;
  logic       txLine, emptyIrq, overflowFlag;
  logic [4:0] fillCount;

  int checks = 0;
  int errors = 0;
  int tickDiv = 1;
  int tickPhase = 0;
  logic [7:0] batch [16];

  always #10 clk = ~clk;

  async_tx_channel dut_i (
    .clk(clk), .rst_n(rst_n), .sampleTick(sampleTick), .wrEn(wrEn), .wrData(wrData),
    .cfgSevenBit(cfgSevenBit), .cfgParityOn(cfgParityOn), .cfgParityOdd(cfgParityOdd),
    .cfgTwoStop(cfgTwoStop), .ctsN(ctsN), .txLine(txLine), .fillCount(fillCount),
    .emptyIrq(emptyIrq), .overflowFlag(overflowFlag)
  );

  always @(negedge clk) begin
    tickPhase  = (tickPhase + 1) % tickDiv;
    sampleTick = (tickPhase == 0);
  end

  function automatic int bitCyc();
    return 16 * tickDiv;
  endfunction

  function automatic logic [7:0] maskData(input logic [7:0] b, input bit seven);
    return seven ? {1'b0, b[6:0]} : b;
  endfunction

  function automatic logic expParity(input logic [7:0] b, input bit seven, input bit odd);
    return (^maskData(b, seven)) ^ odd;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [7:0] b);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic recvFrame(input logic [7:0] exp, input bit seven, input bit parOn,
                           input bit odd, input bit two);
    logic [7:0] got;
    int nb;
    got = '0;
    nb = seven ? 7 : 8;
    @(negedge clk);
    while (txLine !== 1'b0) @(negedge clk);
    repeat (bitCyc() / 2) @(negedge clk);
    check(txLine == 1'b0, "R2 start bit", txLine, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (bitCyc()) @(negedge clk);
      got[i] = txLine;
    end
    check(got == maskData(exp, seven), "R2 data bits", got, maskData(exp, seven));
    if (parOn) begin
      repeat (bitCyc()) @(negedge clk);
      check(txLine == expParity(exp, seven, odd), "R3 parity bit", txLine,
            expParity(exp, seven, odd));
    end
    repeat (bitCyc()) @(negedge clk);
    check(txLine == 1'b1, "R4 first stop bit", txLine, 1);
    if (two) begin
      repeat (bitCyc()) @(negedge clk);
      check(txLine == 1'b1, "R4 second stop bit", txLine, 1);
    end
  endtask

  task automatic measureStart(input logic [7:0] b);
    int lowCyc;
    lowCyc = 0;
    wrByte(b);
    @(negedge clk);
    while (txLine !== 1'b0) @(negedge clk);
    while (txLine === 1'b0) begin
      lowCyc++;
      @(negedge clk);
    end
    check(lowCyc == bitCyc(), "R5 start bit length", lowCyc, bitCyc());
    repeat (12 * bitCyc()) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1 line idle", txLine, 1);
    check(fillCount == 0, "R1 fill count", fillCount, 0);
    check(emptyIrq == 1'b1, "R1 empty request", emptyIrq, 1);
    check(overflowFlag == 1'b0, "R1 overflow flag", overflowFlag, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5117));
    doReset();

    // R8: write clears the empty request, fill count tracks it (R6)
    ctsN = 1'b1;
    wrByte(8'h5A);
    @(negedge clk);
    check(emptyIrq == 1'b0, "R8 request drops after write", emptyIrq, 0);
    check(fillCount == 1, "R6 count after one write", fillCount, 1);
    // R7: held back while clear-to-send is high
    repeat (200) @(negedge clk);
    check(txLine == 1'b1 && fillCount == 1, "R7 no start while blocked",
          {txLine, fillCount}, {1'b1, 5'd1});
    ctsN = 1'b0;
    recvFrame(8'h5A, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    check(fillCount == 0, "R6 count after drain", fillCount, 0);
    check(emptyIrq == 1'b1, "R8 request after drain", emptyIrq, 1);

    // R5: bit timing at two enable rates
    measureStart(8'hA5);
    tickDiv = 3;
    repeat (6) @(negedge clk);
    measureStart(8'hC3);
    cfgParityOn = 1'b1; cfgParityOdd = 1'b1; cfgTwoStop = 1'b1;
    fork
      wrByte(8'h96);
      recvFrame(8'h96, 0, 1, 1, 1);
    join
    repeat (2 * bitCyc()) @(negedge clk);
    tickDiv = 1;
    repeat (6) @(negedge clk);

    // R7: raising clear-to-send mid-character finishes it, blocks the next
    cfgParityOn = 1'b0; cfgParityOdd = 1'b0; cfgTwoStop = 1'b0;
    ctsN = 1'b1;
    wrByte(8'h11); wrByte(8'h22); wrByte(8'h33);
    ctsN = 1'b0;
    fork
      recvFrame(8'h11, 0, 0, 0, 0);
      begin
        @(negedge clk);
        while (txLine !== 1'b0) @(negedge clk);
        repeat (20) @(negedge clk);
        ctsN = 1'b1;
      end
    join
    repeat (3 * bitCyc()) @(negedge clk);
    check(fillCount == 2 && txLine == 1'b1, "R7 next character held",
          {txLine, fillCount}, {1'b1, 5'd2});
    ctsN = 1'b0;
    recvFrame(8'h22, 0, 0, 0, 0);
    recvFrame(8'h33, 0, 0, 0, 0);
    repeat (2 * bitCyc()) @(negedge clk);

    // R10: format change mid-character has no effect on it
    fork
      wrByte(8'hBC);
      recvFrame(8'hBC, 0, 0, 0, 0);
      begin
        @(negedge clk);
        while (txLine !== 1'b0) @(negedge clk);
        repeat (40) @(negedge clk);
        cfgSevenBit = 1'b1; cfgParityOn = 1'b1; cfgTwoStop = 1'b1;
      end
    join
    repeat (2 * bitCyc()) @(negedge clk);
    check(txLine == 1'b1 && fillCount == 0, "R10 line idle after latched frame",
          {txLine, fillCount}, {1'b1, 5'd0});

    // Random batches over all formats (R2 R3 R4 R6)
    for (int it = 0; it < 30; it++) begin
      int n;
      logic [3:0] fmt;
      fmt = 4'($urandom);
      n = 1 + ($urandom % 6);
      cfgSevenBit = fmt[0]; cfgParityOn = fmt[1]; cfgParityOdd = fmt[2]; cfgTwoStop = fmt[3];
      for (int k = 0; k < n; k++) batch[k] = 8'($urandom);
      fork
        begin
          for (int k = 0; k < n; k++) begin
            wrByte(batch[k]);
            repeat ($urandom % 40) @(negedge clk);
          end
        end
        begin
          for (int k = 0; k < n; k++)
            recvFrame(batch[k], fmt[0], fmt[1], fmt[2], fmt[3]);
        end
      join
      repeat (2 * bitCyc()) @(negedge clk);
      check(fillCount == 0 && emptyIrq == 1'b1, "R8 drained after batch",
            {emptyIrq, fillCount}, {1'b1, 5'd0});
    end

    // R9: overflow on a full queue, R6 order and depth
    cfgSevenBit = 1'b0; cfgParityOn = 1'b0; cfgParityOdd = 1'b0; cfgTwoStop = 1'b0;
    ctsN = 1'b1;
    for (int k = 0; k < 16; k++) begin
      batch[k] = 8'(8'h40 + 3 * k);
      wrByte(batch[k]);
    end
    @(negedge clk);
    check(fillCount == 16, "R6 full count", fillCount, 16);
    check(overflowFlag == 1'b0, "R9 no overflow at exactly full", overflowFlag, 0);
    wrByte(8'hEE);
    @(negedge clk);
    check(overflowFlag == 1'b1, "R9 overflow set", overflowFlag, 1);
    check(fillCount == 16, "R9 count unchanged", fillCount, 16);
    ctsN = 1'b0;
    for (int k = 0; k < 16; k++) recvFrame(batch[k], 0, 0, 0, 0);
    repeat (3 * bitCyc()) @(negedge clk);
    check(txLine == 1'b1 && fillCount == 0, "R9 dropped byte not sent",
          {txLine, fillCount}, {1'b1, 5'd0});
    check(overflowFlag == 1'b1, "R9 overflow sticky", overflowFlag, 1);

    doReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule